// File: doc/BRIEF.md
# Latch-Steered Register Front End

This block sits between a byte-wide bus and the older register personality of a disk controller. No register is addressed directly. Each accepted access, read or write, first sets or clears one bit of an 8-bit steering latch, chosen by the bus address. Three bits of the updated latch then select one of eight registers for that same access. Reads return a fixed pattern that depends on the selected register. Writes store their byte in a register file that neighbouring logic can see.

Writes that land on the mode register also drive a small key detector. Bit 6 of each such write is compared with a fixed four-step key. When the last step matches, the block pulses a request that tells the surrounding controller to hand the bus over to its newer register personality. While that personality owns the bus, `active_i` is low and this block ignores all accesses. When control comes back, the controller pulses `load_i` to clear the latch.

Top module: `lrf_front`

## Requirements
- R1: The register offset is the bus address shifted right by 9 bits, so address bits 8..0 have no effect. Offset bits 3..1 pick a latch bit, and offset bit 0 is the value written into that bit.
- R2: An accepted access of either direction changes only the latch bit that the offset picks. Setting a bit and clearing it both work.
- R3: The selected index is {latch[7], latch[6], latch[4]}, most significant bit first, taken from the latch after the access has updated it. A read returns 0xFF on `rd_data_o` when the index is 0 and 0x00 otherwise. The value appears from the clock edge that takes the read and holds until the next accepted read.
- R4: An accepted write stores its data byte in entry `index` of the register file. That entry appears on `regs_o[index*8 +: 8]` from the clock edge that takes the write.
- R5: For writes whose index is 6, bit 6 of the data steps a detector that expects 1, then 0, then 1, then 1. After the fourth matching step, `switch_req_o` is high for exactly one cycle, following the clock edge that takes that write, and the detector returns to its first step.
- R6: A step that does not match leaves the detector where it is. Writes to any other index and all reads leave the detector unchanged.
- R7: While `active_i` is low, accesses change neither the latch, the register file, the read value nor the detector.
- R8: A high `load_i` clears the latch at the next clock edge. An access in that same cycle is ignored.
- R9: A synchronous active-high `rst` clears the latch, the register file, the detector, `rd_data_o` and `switch_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| active_i | input | 1 | High while this register personality owns the bus |
| load_i | input | 1 | Clears the steering latch on return to this personality |
| acc_valid_i | input | 1 | A bus access is presented this cycle |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_addr_i | input | 13 | Bus address; bits 12..9 form the offset |
| acc_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Value of the last accepted read |
| regs_o | output | 64 | Register file, entry i on bits i*8+7..i*8 |
| switch_req_o | output | 1 | One-cycle request to switch personality |

## Verification
The assertions assume that every input is synchronous to `clk` and is driven to a known level in each cycle. They also assume that `rst` is held for at least one edge before any checked behaviour is expected. The stimulus meets these conditions: it changes inputs only on the falling edge, drives every input from time zero, and holds reset for several cycles. The bench holds `acc_valid_i` for one cycle per access and inserts an idle cycle between accesses, so each result is compared against a single expected item. Accesses with `load_i` high or `active_i` low are driven on purpose, because the latch and detector assertions cover those cycles.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int LATCH_W = 8;
  localparam int SEL_W   = 3;
  localparam int OFF_W   = SEL_W + 1;

  typedef enum logic [1:0] {
    U_WANT_1A = 2'd0,
    U_WANT_0  = 2'd1,
    U_WANT_1B = 2'd2,
    U_WANT_1C = 2'd3
  } unlock_t;

  typedef struct packed {
    unlock_t nxt;
    logic    fire;
  } unlock_step_t;

  // Offset bits [3:1] pick a latch bit, bit 0 is its new value.
  function automatic logic [LATCH_W-1:0] latch_apply(
      input logic [LATCH_W-1:0] cur, input logic [OFF_W-1:0] off);
    logic [LATCH_W-1:0] r;
    r = cur;
    r[off[OFF_W-1:1]] = off[0];
    return r;
  endfunction

  function automatic logic [2:0] reg_index(input logic [LATCH_W-1:0] l);
    return {l[7], l[6], l[4]};
  endfunction

  function automatic logic [7:0] read_pattern(input logic [2:0] idx);
    return (idx == 3'd0) ? 8'hFF : 8'h00;
  endfunction

  // Key 1,0,1,1 ; a mismatch holds the current step.
  function automatic unlock_step_t unlock_next(input unlock_t st, input logic k);
    unlock_step_t r;
    r.nxt  = st;
    r.fire = 1'b0;
    case (st)
      U_WANT_1A: if (k)  r.nxt = U_WANT_0;
      U_WANT_0:  if (!k) r.nxt = U_WANT_1B;
      U_WANT_1B: if (k)  r.nxt = U_WANT_1C;
      U_WANT_1C: if (k) begin r.nxt = U_WANT_1A; r.fire = 1'b1; end
      default:   r.nxt = U_WANT_1A;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lrf_addr_latch.sv
module lrf_addr_latch
  import lrf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               fire_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [LATCH_W-1:0] latch_o,
  output logic [2:0]         idx_o
);
  logic [LATCH_W-1:0] latch_q;
  logic [LATCH_W-1:0] latch_nxt;

  assign latch_nxt = latch_apply(latch_q, off_i);
  assign idx_o     = reg_index(latch_nxt);
  assign latch_o   = latch_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) latch_q <= '0;
    else if (fire_i)   latch_q <= latch_nxt;
  end

  p_one_bit_r2: assert property (@(posedge clk) disable iff (rst)
    fire_i && !load_i |=> $countones(latch_q ^ $past(latch_q)) <= 1);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fire_i && !load_i |=> $stable(latch_q));
  p_load_clear_r8: assert property (@(posedge clk) disable iff (rst)
    load_i |=> latch_q == '0);
endmodule

// File: rtl/lrf_regfile.sv
module lrf_regfile #(
  parameter int NREG   = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) mem_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
  end

  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    we_i |=> mem_q[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/lrf_unlock.sv
module lrf_unlock
  import lrf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic key_i,
  output logic pulse_o
);
  unlock_t      state_q;
  unlock_step_t step_res;

  assign step_res = unlock_next(state_q, key_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= U_WANT_1A;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= step_i && step_res.fire;
      if (step_i) state_q <= step_res.nxt;
    end
  end

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> state_q == U_WANT_1A);
  p_miss_holds_r6: assert property (@(posedge clk) disable iff (rst)
    step_i && state_q == U_WANT_0 && key_i |=> state_q == U_WANT_0);
  p_no_step_r6: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(state_q) && !pulse_o);
endmodule

// File: rtl/lrf_front.sv
module lrf_front
  import lrf_pkg::*;
#(
  parameter int REG_SHIFT = 9,
  parameter int DATA_W    = 8,
  parameter int NREG      = 8,
  parameter int MODE_IDX  = 6,
  parameter int KEY_BIT   = 6,
  localparam int ADDR_W   = REG_SHIFT + OFF_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   active_i,
  input  logic                   load_i,
  input  logic                   acc_valid_i,
  input  logic                   acc_write_i,
  input  logic [ADDR_W-1:0]      acc_addr_i,
  input  logic [DATA_W-1:0]      acc_wdata_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   switch_req_o
);
  function automatic logic [OFF_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return OFF_W'(a >> REG_SHIFT);
  endfunction

  logic               acc_fire;
  logic               wr_fire;
  logic               rd_fire;
  logic               key_step;
  logic [OFF_W-1:0]   acc_off;
  logic [2:0]         sel_idx;
  logic [LATCH_W-1:0] latch_now;

  assign acc_fire = acc_valid_i && active_i && !load_i;
  assign wr_fire  = acc_fire && acc_write_i;
  assign rd_fire  = acc_fire && !acc_write_i;
  assign acc_off  = offset_of(acc_addr_i);
  assign key_step = wr_fire && (sel_idx == 3'(MODE_IDX));

  lrf_addr_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .fire_i  (acc_fire),
    .off_i   (acc_off),
    .latch_o (latch_now),
    .idx_o   (sel_idx)
  );

  lrf_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_fire),
    .idx_i   ($clog2(NREG)'(sel_idx)),
    .wdata_i (acc_wdata_i),
    .regs_o  (regs_o)
  );

  lrf_unlock u_unlock (
    .clk     (clk),
    .rst     (rst),
    .step_i  (key_step),
    .key_i   (acc_wdata_i[KEY_BIT]),
    .pulse_o (switch_req_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_fire) rd_data_o <= DATA_W'(read_pattern(sel_idx));
  end

  p_read_pair_r3: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> (rd_data_o == DATA_W'(8'hFF)) || (rd_data_o == '0));
  p_read_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rd_data_o));
  p_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !active_i |=> !switch_req_o && $stable(regs_o) && $stable(latch_now));
endmodule

// File: tb/lrf_front_tb.sv
`timescale 1ns/1ps
module lrf_front_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        active_i = 1'b1;
  logic        load_i = 1'b0;
  logic        acc_valid_i = 1'b0;
  logic        acc_write_i = 1'b0;
  logic [12:0] acc_addr_i = '0;
  logic [7:0]  acc_wdata_i = '0;
  logic [7:0]  rd_data_o;
  logic [63:0] regs_o;
  logic        switch_req_o;

  always #4 clk = ~clk;

  lrf_front dut_i (.*);

  typedef struct {
    logic [7:0]  rd;
    logic        sw;
    logic [63:0] regs;
    string       tag;
  } item_t;
  item_t exp_q[$];

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_latch;
  logic [7:0] m_regs [8];
  int         m_st;
  logic [7:0] m_rd;

  function automatic logic [63:0] pack_regs();
    logic [63:0] p;
    for (int i = 0; i < 8; i++) p[i*8 +: 8] = m_regs[i];
    return p;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_latch = '0; m_st = 0; m_rd = '0;
    for (int i = 0; i < 8; i++) m_regs[i] = '0;
  endtask

  // Driver: one access, then an idle cycle. Pushes the expected outcome.
  task automatic acc(string tag, bit wr, int lb, bit v, logic [7:0] d,
                     bit act = 1, bit ld = 0, int low = 0);
    item_t it;
    logic [2:0] idx;
    logic sw;
    @(negedge clk);
    acc_valid_i = 1'b1; acc_write_i = wr; acc_wdata_i = d;
    active_i = act; load_i = ld;
    acc_addr_i = 13'(((lb * 2 + int'(v)) << 9) | low);
    sw = 1'b0;
    if (ld) m_latch = '0;
    else if (act) begin
      m_latch[lb] = v;
      idx = {m_latch[7], m_latch[6], m_latch[4]};
      if (wr) begin
        m_regs[idx] = d;
        if (idx == 3'd6) begin
          case (m_st)
            0: if (d[6])  m_st = 1;
            1: if (!d[6]) m_st = 2;
            2: if (d[6])  m_st = 3;
            default: if (d[6]) begin m_st = 0; sw = 1'b1; end
          endcase
        end
      end else m_rd = (idx == 3'd0) ? 8'hFF : 8'h00;
    end
    it.rd = m_rd; it.sw = sw; it.regs = pack_regs(); it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    acc_valid_i = 1'b0; active_i = 1'b1; load_i = 1'b0;
  endtask

  // Monitor: compares each expected item just after the edge that takes it.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check({it.tag, " rd"},   64'(rd_data_o),    64'(it.rd));
      check({it.tag, " sw"},   64'(switch_req_o), 64'(it.sw));
      check({it.tag, " regs"}, regs_o,            it.regs);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    model_reset();
    rst = 1'b0;
    check("R9 reset rd", 64'(rd_data_o), 64'h0);
    check("R9 reset sw", 64'(switch_req_o), 64'h0);
    check("R9 reset regs", regs_o, 64'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1/R3: low address bits ignored, index 0 reads 0xFF
    acc("R1 low bits", 0, 0, 1, 8'h00, 1, 0, 9'h1FF);
    acc("R3 idx1 read", 0, 4, 1, 8'h00);
    acc("R2 clear bit4", 0, 4, 0, 8'h00);
    // R4: writes land in the selected entry
    acc("R4 write idx4", 1, 7, 1, 8'hA5);
    acc("R4 write idx6", 1, 6, 1, 8'h3C);
    // R5: key 1,0,1,1 on mode register
    acc("R5 step1", 1, 4, 0, 8'h40);
    acc("R5 step2", 1, 4, 0, 8'h00);
    acc("R5 step3", 1, 4, 0, 8'h41);
    acc("R5 step4 fire", 1, 4, 0, 8'hC0);
    // R6: misses hold the step
    acc("R6 s1", 1, 0, 0, 8'h40);
    acc("R6 miss hold", 1, 0, 0, 8'h40);
    acc("R6 s2", 1, 0, 0, 8'h00);
    acc("R6 miss hold2", 1, 0, 0, 8'h00);
    acc("R6 s3", 1, 0, 0, 8'h40);
    acc("R6 miss hold3", 1, 0, 0, 8'h00);
    acc("R6 fire", 1, 0, 0, 8'h40);
    // R6: other index and reads do not advance
    acc("R6 idx7 write", 1, 4, 1, 8'h40);
    acc("R6 back to 6", 0, 4, 0, 8'h00);
    acc("R6 s1b", 1, 1, 1, 8'h40);
    acc("R6 idx7 zero", 1, 4, 1, 8'h00);
    acc("R6 read to 6", 0, 4, 0, 8'h00);
    acc("R6 s2b", 1, 1, 0, 8'h00);
    acc("R6 s3b", 1, 1, 0, 8'h40);
    acc("R6 fire b", 1, 1, 0, 8'h40);
    // R7: inactive access ignored, latch kept (write lands at 6)
    acc("R7 inactive", 1, 7, 0, 8'hEE, 0);
    acc("R7 inactive read", 0, 6, 0, 8'h00, 0);
    acc("R7 latch kept", 1, 0, 1, 8'h11);
    // R8: load clears latch, access ignored
    acc("R8 load", 1, 0, 1, 8'h22, 1, 1);
    acc("R8 idx0 after load", 0, 1, 0, 8'h00);
    // R9: mid-run reset clears the detector
    acc("R9 prep idx6 a", 1, 7, 1, 8'h00);
    acc("R9 prep idx6 b", 1, 6, 1, 8'h40);
    acc("R9 prep s2", 1, 0, 0, 8'h00);
    acc("R9 prep s3", 1, 0, 0, 8'h40);
    do_reset();
    acc("R9 re idx6 a", 1, 7, 1, 8'h00);
    acc("R9 re idx6 b", 1, 6, 1, 8'h00);
    acc("R9 no fire", 1, 0, 0, 8'h40);
    acc("R3 read idx6", 0, 2, 1, 8'h00);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule